// File: doc/BRIEF.md
# Integer arithmetic execution unit

This block is the arithmetic stage of one lane in a processor pipeline. Each cycle it may accept two 64-bit register operands, an immediate that the decoder has already sign-extended to 64 bits, and an operation code. One clock later it presents a 64-bit result and a flag that marks an operation code it does not implement.

The operations fall into these groups. Full-width add and subtract wrap modulo 2^64. The 32-bit forms keep only bit 31 and below of the 64-bit sum and sign-extend that value to 64 bits. The saturating 32-bit add and subtract clamp their result into the signed 32-bit range. The scaled add shifts the first operand left by 1, 2 or 3 bits before it adds the second operand, in both a full-width form and a 32-bit form. There is an immediate add in both forms. A shift-by-16-and-insert operation builds wide constants 16 bits at a time.

The output stage is a two-state machine. ST_EMPTY means no result is presented, and ST_FULL means out_valid is high. The transitions are CAPTURE (ST_EMPTY to ST_FULL when in_valid is high), STREAM (ST_FULL stays in ST_FULL when in_valid is high), DRAIN (ST_FULL to ST_EMPTY when in_valid is low) and IDLE (ST_EMPTY stays in ST_EMPTY when in_valid is low). A synchronous active-high reset forces ST_EMPTY.

Top module: `arith_exec_unit`

## Requirements
- R1: While rst is high at a clock edge, and after that edge, out_valid, out_unsup and out_result are all zero.
- R2: Operation codes 0 (add), 1 (subtract a-b) and 12 (add immediate a+imm) give the full 64-bit result modulo 2^64, with no saturation.
- R3: Operation codes 2 (add), 3 (subtract a-b) and 13 (add immediate) compute the 64-bit result and then set bits 63..32 to copies of bit 31.
- R4: Operation codes 4 (saturating add) and 5 (saturating subtract a-b) sign-extend bits 31..0 of each operand and operate at 64 bits. They clamp the result to the range [-0x80000000, 0x7FFFFFFF] and output it sign-extended to 64 bits.
- R5: Operation codes 6, 7 and 8 give (a << 1) + b, (a << 2) + b and (a << 3) + b, keeping all 64 bits.
- R6: Operation codes 9, 10 and 11 compute the same scaled sums with shifts of 1, 2 and 3, and then sign-extend bit 31 of the sum into bits 63..32.
- R7: Operation code 14 gives (a << 16) OR imm[15:0]. Bits 63..16 of imm have no effect.
- R8: When in_valid is high at an edge, out_valid is high after that edge and out_result carries the result for those inputs. When in_valid is low at an edge, out_valid is low after it and out_result keeps its value.
- R9: Operation codes 15 to 31 (in_op is 5 bits) give out_result zero and out_unsup one. Every supported code gives out_unsup zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid and are captured this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 64 | First register operand |
| in_b | input | 64 | Second register operand |
| in_imm | input | 64 | Immediate, already sign-extended |
| out_valid | output | 1 | Result is presented |
| out_result | output | 64 | Registered result |
| out_unsup | output | 1 | Operation code was not supported |

## Verification
Every result, and its flag, is due exactly one rising edge after the cycle in which in_valid was high. The bench drives inputs on a falling edge and samples outputs on the next falling edge, which lies half a period after the single capturing edge. One back-to-back pair confirms that a second operation does not disturb the first operation's sample point. A following idle cycle confirms that out_valid drops and out_result holds.

// File: rtl/arith_pkg.sv
package arith_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = 32;
    localparam int INS_W = 16;
    localparam int OP_W  = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD      = 5'd0,
        OP_SUB      = 5'd1,
        OP_ADD32    = 5'd2,
        OP_SUB32    = 5'd3,
        OP_ADDSAT   = 5'd4,
        OP_SUBSAT   = 5'd5,
        OP_SHADD1   = 5'd6,
        OP_SHADD2   = 5'd7,
        OP_SHADD3   = 5'd8,
        OP_SHADD1W  = 5'd9,
        OP_SHADD2W  = 5'd10,
        OP_SHADD3W  = 5'd11,
        OP_ADDI     = 5'd12,
        OP_ADDI32   = 5'd13,
        OP_SHINS16  = 5'd14
    } op_t;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } vstate_t;

    function automatic logic [XLEN-1:0] sext_low(input logic [XLEN-1:0] v);
        return {{(XLEN-HALF){v[HALF-1]}}, v[HALF-1:0]};
    endfunction
endpackage

// File: rtl/arith_shadd.sv
module arith_shadd #(
    parameter int DATA_W = arith_pkg::XLEN,
    parameter int SHIFT  = 1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] full_sum,
    output logic [DATA_W-1:0] word_sum
);
    always_comb begin
        full_sum = (a << SHIFT) + b;
        word_sum = arith_pkg::sext_low(full_sum);
    end
endmodule

// File: rtl/arith_sat32.sv
module arith_sat32 #(
    parameter int DATA_W = arith_pkg::XLEN,
    parameter int HALF_W = arith_pkg::HALF,
    parameter bit SUB    = 1'b0
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam logic signed [DATA_W-1:0] SMAX =
        {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] SMIN = ~SMAX;

    logic signed [DATA_W-1:0] ea, eb, raw;

    always_comb begin
        ea  = arith_pkg::sext_low(a);
        eb  = arith_pkg::sext_low(b);
        raw = SUB ? (ea - eb) : (ea + eb);
        if (raw > SMAX)
            res = SMAX;
        else if (raw < SMIN)
            res = SMIN;
        else
            res = raw;
    end

    always_comb begin
        assert_sat_range_R4: assert (res[DATA_W-1:HALF_W-1] ==
                                     {(DATA_W-HALF_W+1){res[HALF_W-1]}});
    end
endmodule

// File: rtl/arith_core.sv
module arith_core #(
    parameter int DATA_W = arith_pkg::XLEN,
    parameter int OPW    = arith_pkg::OP_W,
    parameter int INSW   = arith_pkg::INS_W
) (
    input  logic [OPW-1:0]    op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] res,
    output logic              unsup
);
    import arith_pkg::*;

    localparam int NSH = 3;

    logic [DATA_W-1:0] sh_full [1:NSH];
    logic [DATA_W-1:0] sh_word [1:NSH];
    logic [DATA_W-1:0] sat_add, sat_sub;
    logic [DATA_W-1:0] sum_ab, dif_ab, sum_ai;
    logic              is_word;

    for (genvar g = 1; g <= NSH; g++) begin : g_shadd
        arith_shadd #(.DATA_W(DATA_W), .SHIFT(g)) u_sh (
            .a(a), .b(b), .full_sum(sh_full[g]), .word_sum(sh_word[g])
        );
    end

    arith_sat32 #(.DATA_W(DATA_W), .SUB(1'b0)) u_sat_add (.a(a), .b(b), .res(sat_add));
    arith_sat32 #(.DATA_W(DATA_W), .SUB(1'b1)) u_sat_sub (.a(a), .b(b), .res(sat_sub));

    always_comb begin
        sum_ab  = a + b;
        dif_ab  = a - b;
        sum_ai  = a + imm;
        unsup   = 1'b0;
        is_word = 1'b0;
        res     = '0;
        case (op)
            OP_ADD:     res = sum_ab;
            OP_SUB:     res = dif_ab;
            OP_ADDI:    res = sum_ai;
            OP_ADD32:   begin res = sext_low(sum_ab); is_word = 1'b1; end
            OP_SUB32:   begin res = sext_low(dif_ab); is_word = 1'b1; end
            OP_ADDI32:  begin res = sext_low(sum_ai); is_word = 1'b1; end
            OP_ADDSAT:  res = sat_add;
            OP_SUBSAT:  res = sat_sub;
            OP_SHADD1:  res = sh_full[1];
            OP_SHADD2:  res = sh_full[2];
            OP_SHADD3:  res = sh_full[3];
            OP_SHADD1W: begin res = sh_word[1]; is_word = 1'b1; end
            OP_SHADD2W: begin res = sh_word[2]; is_word = 1'b1; end
            OP_SHADD3W: begin res = sh_word[3]; is_word = 1'b1; end
            OP_SHINS16: res = (a << INSW) | {{(DATA_W-INSW){1'b0}}, imm[INSW-1:0]};
            default:    unsup = 1'b1;
        endcase
    end

    always_comb begin
        if (is_word)
            assert_word_ext_R3: assert (res[DATA_W-1:DATA_W/2] == {(DATA_W/2){res[DATA_W/2-1]}});
    end
endmodule

// File: rtl/arith_exec_unit.sv
module arith_exec_unit #(
    parameter int DATA_W = arith_pkg::XLEN,
    parameter int OPW    = arith_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPW-1:0]    in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_unsup
);
    import arith_pkg::*;

    vstate_t           state, nxt;
    logic [DATA_W-1:0] core_res;
    logic              core_unsup;

    arith_core #(.DATA_W(DATA_W), .OPW(OPW)) u_core (
        .op(in_op), .a(in_a), .b(in_b), .imm(in_imm),
        .res(core_res), .unsup(core_unsup)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  nxt = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_EMPTY;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_unsup  <= 1'b0;
        end else if (in_valid) begin
            out_result <= core_res;
            out_unsup  <= core_unsup;
        end
    end

    assign out_valid = (state == ST_FULL);

    assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));
    assert_unsup_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unsup) |-> (out_result == '0));
endmodule

// File: tb/sim_arith_exec_unit.sv
module sim_arith_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [63:0] in_a = '0, in_b = '0, in_imm = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_unsup;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    arith_exec_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
        .out_valid(out_valid), .out_result(out_result), .out_unsup(out_unsup)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    task automatic drive(input logic [4:0] op, input logic [63:0] a, b, imm);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm;
    endtask

    task automatic run_op(input string tag, input logic [4:0] op,
                          input logic [63:0] a, b, imm, exp, input logic exp_unsup);
        @(negedge clk);
        drive(op, a, b, imm);
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check({tag, " result"}, out_result, exp);
        check({tag, " unsup"}, {63'd0, out_unsup}, {63'd0, exp_unsup});
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", out_result, 64'd0);
        check("R1 unsup", {63'd0, out_unsup}, 64'd0);
    endtask

    task automatic t_full;
        run_op("R2 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0, 64'd1, 1'b0);
        run_op("R2 sub wrap", 5'd1, 64'd0, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op("R2 addi", 5'd12, 64'd5, 64'd99, -64'sd3, 64'd2, 1'b0);
    endtask

    task automatic t_word;
        run_op("R3 add32", 5'd2, 64'h7FFF_FFFF, 64'd1, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0);
        run_op("R3 sub32", 5'd3, 64'h1_0000_0000, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op("R3 addi32", 5'd13, 64'h1234_5678_0000_0010, 64'd0, -64'sd32,
               sx(64'h1234_5678_0000_0010 - 64'd32), 1'b0);
    endtask

    task automatic t_sat;
        run_op("R4 addsat max", 5'd4, 64'h7FFF_FFFF, 64'd1, 64'd0, 64'h0000_0000_7FFF_FFFF, 1'b0);
        run_op("R4 subsat min", 5'd5, 64'h8000_0000, 64'd1, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0);
        run_op("R4 addsat in range", 5'd4, 64'hDEAD_0000_0000_0005, 64'hBEEF_0000_0000_0003,
               64'd0, 64'd8, 1'b0);
        run_op("R4 subsat pos clamp", 5'd5, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 64'd0,
               64'h0000_0000_7FFF_FFFF, 1'b0);
        run_op("R4 addsat neg clamp", 5'd4, 64'h8000_0000, 64'h8000_0000, 64'd0,
               64'hFFFF_FFFF_8000_0000, 1'b0);
        run_op("R4 subsat neg result", 5'd5, 64'd2, 64'd7, 64'd0, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0);
    endtask

    task automatic t_shadd;
        run_op("R5 shadd1", 5'd6, 64'h8000_0000_0000_0001, 64'd3, 64'd0, 64'd5, 1'b0);
        run_op("R5 shadd2", 5'd7, 64'h10, 64'd1, 64'd0, 64'h41, 1'b0);
        run_op("R5 shadd3", 5'd8, 64'h1000_0000_0000_0000, 64'd1, 64'd0, 64'h8000_0000_0000_0001, 1'b0);
        run_op("R6 shadd1w", 5'd9, 64'h4000_0000, 64'd0, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0);
        run_op("R6 shadd2w", 5'd10, 64'd3, 64'h10_0000_0004, 64'd0, 64'h10, 1'b0);
        run_op("R6 shadd3w", 5'd11, 64'h1FFF_FFFF, 64'd8, 64'd0, 64'd0, 1'b0);
    endtask

    task automatic t_ins;
        run_op("R7 shins16", 5'd14, 64'h0000_1234_5678_9ABC, 64'd0, 64'hFFFF_FFFF_FFFF_CDEF,
               64'h1234_5678_9ABC_CDEF, 1'b0);
        run_op("R7 upper imm ignored", 5'd14, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_0000,
               64'h1_0000, 1'b0);
    endtask

    task automatic t_unsup;
        run_op("R9 op15", 5'd15, 64'd7, 64'd9, 64'd1, 64'd0, 1'b1);
        run_op("R9 op31", 5'd31, 64'hFFFF, 64'd1, 64'd1, 64'd0, 1'b1);
    endtask

    task automatic t_timing;
        @(negedge clk);
        drive(5'd0, 64'd10, 64'd20, 64'd0);
        @(negedge clk);
        check("R8 first valid", {63'd0, out_valid}, 64'd1);
        check("R8 first result", out_result, 64'd30);
        drive(5'd1, 64'd10, 64'd20, 64'd0);
        @(negedge clk);
        check("R8 second valid", {63'd0, out_valid}, 64'd1);
        check("R8 second result", out_result, 64'hFFFF_FFFF_FFFF_FFF6);
        drive(5'd2, 64'd1, 64'd1, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 idle valid", {63'd0, out_valid}, 64'd0);
        check("R8 idle hold", out_result, 64'hFFFF_FFFF_FFFF_FFF6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full();
        t_word();
        t_sat();
        t_shadd();
        t_ins();
        t_unsup();
        t_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule